// File: doc/BRIEF.md
# PLL Reference Switchover Controller

This block chooses which of two reference clocks, called reference A and reference B, feeds a PLL. In manual operation the choice comes from a configuration bit or from an external select pin. In automatic operation it follows per-reference health inputs from external frequency monitors. When the active reference fails and the other one is healthy, the block fails over to the other one. After a failover to reference B it can return to reference A once A is healthy again, or it can stay latched on B. When both references are unhealthy it enters holdover and keeps its current choice.

The block also drives the two reference power enables, a selected-reference indicator and a set of active-low health flags. The reference clock output passes through a glitch-free multiplexer. On a handoff, the outgoing clock is gated off during its low phase and the incoming clock is gated on during its own low phase, so the output never carries a shortened high pulse. A configuration bit bypasses this stage and selects the clock directly.

All health inputs and the select pin pass through two-flop synchronizers in the control clock domain. The handoff requests are synchronized again in each reference clock domain.

Top module: `refsw_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with all configuration inputs at 0 and all health inputs at 1, `sel_is_a` is 1, `holdover_n` is 1, and `pwr_a_en` and `pwr_b_en` are 0.
- R2: In manual operation (`cfg_auto`=0, or `cfg_diff`=1) with `cfg_use_pin`=0, `cfg_reg_sel_b`=0 selects reference A (`sel_is_a`=1) and `cfg_reg_sel_b`=1 selects reference B (`sel_is_a`=0).
- R3: In manual operation with `cfg_use_pin`=1, the synchronized `sel_pin` selects the reference: 0 selects A and 1 selects B. `cfg_reg_sel_b` has no effect.
- R4: In automatic operation (`cfg_auto`=1 and `cfg_diff`=0), when the selected reference's health input is 0 and the other one's is 1, the selection moves to the other reference.
- R5: In automatic operation with `cfg_stay_b`=0, while reference B is selected and `mon_a_ok` is 1, the selection returns to reference A.
- R6: In automatic operation with `cfg_stay_b`=1, reference B stays selected while `mon_b_ok` is 1, whatever the value of `mon_a_ok`.
- R7: In automatic operation with both health inputs at 0, `holdover_n` is 0 and the selection does not change. In every other case `holdover_n` is 1.
- R8: `pwr_a_en` and `pwr_b_en` are both 1 whenever `cfg_auto` is 1. Otherwise they follow `cfg_pwr_a` and `cfg_pwr_b`.
- R9: With `cfg_diff`=1, setting `cfg_auto` has no effect on selection or holdover: the block behaves as in manual operation, and `holdover_n` stays 1.
- R10: Health inputs are active high (1 = healthy). `flag_sel_n` is the health of the selected reference, `flag_clk_n` is `mon_clk_ok`, and `flag_combo_n` is the AND of `mon_dld`, the selected reference's health and `mon_clk_ok`. Each flag is low when its condition is faulty.
- R11: With `cfg_deglitch_off`=0, `ref_out` settles to follow the selected reference clock. No high pulse on `ref_out` is shorter than the shorter of the two reference high phases, and the two internal gate enables are never both high.
- R12: With `cfg_deglitch_off`=1, `ref_out` is the selected reference clock passed directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| cfg_auto | input | 1 | 1 = automatic switchover |
| cfg_use_pin | input | 1 | Manual source: 1 = select pin, 0 = register bit |
| cfg_reg_sel_b | input | 1 | Manual register choice: 0 = A, 1 = B |
| cfg_stay_b | input | 1 | 1 = stay on B after failover |
| cfg_pwr_a | input | 1 | Reference A power request |
| cfg_pwr_b | input | 1 | Reference B power request |
| cfg_diff | input | 1 | Differential reference mode; blocks automatic operation |
| cfg_deglitch_off | input | 1 | 1 = bypass the glitch-free multiplexer |
| sel_pin | input | 1 | External asynchronous select: 0 = A, 1 = B |
| mon_a_ok | input | 1 | Reference A healthy |
| mon_b_ok | input | 1 | Reference B healthy |
| mon_clk_ok | input | 1 | Feedback clock healthy |
| mon_dld | input | 1 | Digital lock detect |
| ref_a_clk | input | 1 | Reference A clock |
| ref_b_clk | input | 1 | Reference B clock |
| ref_out | output | 1 | Multiplexed reference clock to the PLL |
| sel_is_a | output | 1 | 1 = A selected, 0 = B selected |
| pwr_a_en | output | 1 | Reference A power enable |
| pwr_b_en | output | 1 | Reference B power enable |
| holdover_n | output | 1 | Low while in holdover |
| flag_sel_n | output | 1 | Low when the selected reference is unhealthy |
| flag_clk_n | output | 1 | Low when the feedback clock is unhealthy |
| flag_combo_n | output | 1 | Low when lock, selected reference or feedback clock is faulty |

## Verification
The bench targets these transitions:
- Failover with the latch-on-B bit set, while reference A recovers. A design that reverts anyway would show `sel_is_a` returning to 1.
- Both references failing from either selection. A design that still switches, or that never raises holdover, would move the selection or leave `holdover_n` high.
- Automatic operation combined with differential mode. A design that still acts automatically would fail over on a health drop.
- Power-enable override. A design that ignores the override would leave the enables off.

Every high pulse on `ref_out` is timed across many random handoffs, so a mux that switches mid-phase reports a runt pulse. Direct-bypass and settled-follow checks catch an output that tracks the wrong clock.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } ref_sel_e;

  localparam int unsigned HEALTH_W = 5;  // {pin, dld, clk_ok, b_ok, a_ok}
endpackage

// File: rtl/refsw_sync.sv
module refsw_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/refsw_select.sv
module refsw_select
  import refsw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     auto_en,
  input  logic     use_pin,
  input  logic     reg_sel_b,
  input  logic     stay_b,
  input  logic     pin_b,
  input  logic     a_ok,
  input  logic     b_ok,
  output ref_sel_e sel_q,
  output logic     holdover_q
);
  ref_sel_e sel_d;
  logic     holdover_d;

  always_comb begin
    sel_d      = sel_q;
    holdover_d = 1'b0;
    if (!auto_en) begin
      sel_d = (use_pin ? pin_b : reg_sel_b) ? SEL_B : SEL_A;
    end else if (!a_ok && !b_ok) begin
      holdover_d = 1'b1;
    end else if (sel_q == SEL_A) begin
      if (!a_ok && b_ok) sel_d = SEL_B;
    end else begin
      if (a_ok && (!b_ok || !stay_b)) sel_d = SEL_A;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= SEL_A;
      holdover_q <= 1'b0;
    end else begin
      sel_q      <= sel_d;
      holdover_q <= holdover_d;
    end
  end
endmodule

// File: rtl/refsw_gfmux.sv
module refsw_gfmux #(
  parameter int unsigned STAGES = 2
) (
  input  logic rst_n,
  input  logic clk_a,
  input  logic clk_b,
  input  logic sel_b,
  input  logic bypass,
  output logic gate_a,
  output logic gate_b,
  output logic clk_out
);
  logic rst_a_n, rst_b_n;
  logic req_a, req_b;
  logic want_a, want_b;

  assign want_a = ~sel_b & ~gate_b;
  assign want_b =  sel_b & ~gate_a;

  refsw_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_rst_a (
    .clk(clk_a), .rst_n(rst_n), .d(1'b1), .q(rst_a_n));
  refsw_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_rst_b (
    .clk(clk_b), .rst_n(rst_n), .d(1'b1), .q(rst_b_n));

  refsw_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_req_a (
    .clk(clk_a), .rst_n(rst_a_n), .d(want_a), .q(req_a));
  refsw_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_req_b (
    .clk(clk_b), .rst_n(rst_b_n), .d(want_b), .q(req_b));

  // Gates change only while their own clock is low.
  always_ff @(negedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n) gate_a <= 1'b0;
    else          gate_a <= req_a;
  end

  always_ff @(negedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n) gate_b <= 1'b0;
    else          gate_b <= req_b;
  end

  assign clk_out = bypass ? (sel_b ? clk_b : clk_a)
                          : ((clk_a & gate_a) | (clk_b & gate_b));
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
  import refsw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_auto,
  input  logic cfg_use_pin,
  input  logic cfg_reg_sel_b,
  input  logic cfg_stay_b,
  input  logic cfg_pwr_a,
  input  logic cfg_pwr_b,
  input  logic cfg_diff,
  input  logic cfg_deglitch_off,
  input  logic sel_pin,
  input  logic mon_a_ok,
  input  logic mon_b_ok,
  input  logic mon_clk_ok,
  input  logic mon_dld,
  input  logic ref_a_clk,
  input  logic ref_b_clk,
  output logic ref_out,
  output logic sel_is_a,
  output logic pwr_a_en,
  output logic pwr_b_en,
  output logic holdover_n,
  output logic flag_sel_n,
  output logic flag_clk_n,
  output logic flag_combo_n
);
  logic [HEALTH_W-1:0] health_raw, health_s;
  logic a_ok_s, b_ok_s, clk_ok_s, dld_s, pin_s;
  logic auto_eff;
  ref_sel_e sel_q;
  logic holdover_q;
  logic pwr_a_d, pwr_b_d, pwr_a_q, pwr_b_q;
  logic sel_ok;
  logic gate_a, gate_b;

  assign health_raw = {sel_pin, mon_dld, mon_clk_ok, mon_b_ok, mon_a_ok};

  refsw_sync #(.WIDTH(HEALTH_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(health_raw), .q(health_s));

  assign {pin_s, dld_s, clk_ok_s, b_ok_s, a_ok_s} = health_s;

  // Automatic switchover needs both status paths, unavailable in differential mode.
  assign auto_eff = cfg_auto & ~cfg_diff;

  refsw_select u_select (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_en   (auto_eff),
    .use_pin   (cfg_use_pin),
    .reg_sel_b (cfg_reg_sel_b),
    .stay_b    (cfg_stay_b),
    .pin_b     (pin_s),
    .a_ok      (a_ok_s),
    .b_ok      (b_ok_s),
    .sel_q     (sel_q),
    .holdover_q(holdover_q)
  );

  always_comb begin
    pwr_a_d = cfg_auto | cfg_pwr_a;
    pwr_b_d = cfg_auto | cfg_pwr_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_a_q <= 1'b0;
      pwr_b_q <= 1'b0;
    end else begin
      pwr_a_q <= pwr_a_d;
      pwr_b_q <= pwr_b_d;
    end
  end

  assign sel_ok = (sel_q == SEL_B) ? b_ok_s : a_ok_s;

  refsw_gfmux #(.STAGES(SYNC_STAGES)) u_mux (
    .rst_n  (rst_n),
    .clk_a  (ref_a_clk),
    .clk_b  (ref_b_clk),
    .sel_b  (sel_q == SEL_B),
    .bypass (cfg_deglitch_off),
    .gate_a (gate_a),
    .gate_b (gate_b),
    .clk_out(ref_out)
  );

  assign sel_is_a     = (sel_q == SEL_A);
  assign pwr_a_en     = pwr_a_q;
  assign pwr_b_en     = pwr_b_q;
  assign holdover_n   = ~holdover_q;
  assign flag_sel_n   = sel_ok;
  assign flag_clk_n   = clk_ok_s;
  assign flag_combo_n = dld_s & sel_ok & clk_ok_s;
endmodule

// File: rtl/refsw_ctrl_chk.sv
module refsw_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_auto,
  input logic cfg_diff,
  input logic cfg_use_pin,
  input logic cfg_reg_sel_b,
  input logic cfg_stay_b,
  input logic sel_is_a,
  input logic holdover_n,
  input logic flag_sel_n,
  input logic pwr_a_en,
  input logic pwr_b_en,
  input logic gate_a,
  input logic gate_b
);
  assert_manual_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_auto && !cfg_use_pin) |=> (sel_is_a == !$past(cfg_reg_sel_b)));

  assert_stay_on_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto && !cfg_diff && cfg_stay_b && !sel_is_a && flag_sel_n) |=> !sel_is_a);

  assert_holdover_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !holdover_n |-> $stable(sel_is_a));

  assert_power_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_auto |=> (pwr_a_en && pwr_b_en));

  assert_diff_no_holdover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto && cfg_diff) |=> holdover_n);

  always_comb begin
    if (rst_n) begin
      assert_gates_exclusive_R11: assert ($onehot0({gate_a, gate_b}));
    end
  end
endmodule

bind refsw_ctrl refsw_ctrl_chk u_chk (.*);

// File: tb/refsw_ctrl_tb_top.sv
module refsw_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REFA_HALF  = 7;
  localparam int REFB_HALF  = 11;
  localparam int SETTLE     = 20;
  localparam int RAND_STEPS = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_auto = 0, cfg_use_pin = 0, cfg_reg_sel_b = 0, cfg_stay_b = 0;
  logic cfg_pwr_a = 0, cfg_pwr_b = 0, cfg_diff = 0, cfg_deglitch_off = 0;
  logic sel_pin = 0, mon_a_ok = 1, mon_b_ok = 1, mon_clk_ok = 1, mon_dld = 1;
  logic ref_a_clk = 1'b0, ref_b_clk = 1'b0;
  logic ref_out, sel_is_a, pwr_a_en, pwr_b_en, holdover_n;
  logic flag_sel_n, flag_clk_n, flag_combo_n;

  int n_checks = 0, n_fails = 0, runts = 0;
  logic exp_b = 1'b0;
  bit mon_en = 1'b0, done = 1'b0;
  longint t_rise = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(REFA_HALF) ref_a_clk = ~ref_a_clk;
  always #(REFB_HALF) ref_b_clk = ~ref_b_clk;

  refsw_ctrl dut_i (.*);

  always @(posedge ref_out) t_rise = $time;
  always @(negedge ref_out) if (mon_en && rst_n && (($time - t_rise) < 6)) runts++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic f_next_b(logic cur_b);
    if (!(cfg_auto && !cfg_diff)) return cfg_use_pin ? sel_pin : cfg_reg_sel_b;
    if (!mon_a_ok && !mon_b_ok) return cur_b;
    if (!cur_b) return (!mon_a_ok && mon_b_ok);
    if (mon_a_ok && (!mon_b_ok || !cfg_stay_b)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic settle_and_check(input string req);
    logic exp_hold, exp_sok;
    exp_b = f_next_b(exp_b);
    repeat (SETTLE) @(negedge clk);
    exp_hold = cfg_auto && !cfg_diff && !mon_a_ok && !mon_b_ok;
    exp_sok  = exp_b ? mon_b_ok : mon_a_ok;
    chk(sel_is_a === !exp_b, {req, " sel_is_a"}, sel_is_a, !exp_b);
    chk(holdover_n === !exp_hold, {req, " R7 holdover_n"}, holdover_n, !exp_hold);
    chk(pwr_a_en === (cfg_auto | cfg_pwr_a), {req, " R8 pwr_a_en"}, pwr_a_en, cfg_auto | cfg_pwr_a);
    chk(pwr_b_en === (cfg_auto | cfg_pwr_b), {req, " R8 pwr_b_en"}, pwr_b_en, cfg_auto | cfg_pwr_b);
    chk(flag_sel_n === exp_sok, {req, " R10 flag_sel_n"}, flag_sel_n, exp_sok);
    chk(flag_clk_n === mon_clk_ok, {req, " R10 flag_clk_n"}, flag_clk_n, mon_clk_ok);
    chk(flag_combo_n === (mon_dld & exp_sok & mon_clk_ok), {req, " R10 flag_combo_n"},
        flag_combo_n, mon_dld & exp_sok & mon_clk_ok);
  endtask

  task automatic check_follow(input logic want_a, input string req);
    int bad = 0;
    for (int i = 0; i < 4; i++) begin
      if (want_a) @(posedge ref_a_clk); else @(posedge ref_b_clk);
      #2; if (ref_out !== 1'b1) bad++;
      if (want_a) @(negedge ref_a_clk); else @(negedge ref_b_clk);
      #2; if (ref_out !== 1'b0) bad++;
    end
    chk(bad == 0, req, bad, 0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(sel_is_a === 1'b1 && holdover_n === 1'b1, "R1 in reset sel/holdover", {sel_is_a, holdover_n}, 3);
    rst_n = 1'b1;
    repeat (SETTLE) @(negedge clk);
    chk(sel_is_a === 1'b1, "R1 sel_is_a after reset", sel_is_a, 1);
    chk(pwr_a_en === 1'b0 && pwr_b_en === 1'b0, "R1 power after reset", {pwr_a_en, pwr_b_en}, 0);
    mon_en = 1'b1;

    // R2 manual register selection
    cfg_reg_sel_b = 1; settle_and_check("R2 reg=B");
    check_follow(1'b0, "R11 follows B after handoff");
    cfg_reg_sel_b = 0; settle_and_check("R2 reg=A");
    check_follow(1'b1, "R11 follows A after handoff");
    // R3 pin selection, register bit ignored
    cfg_use_pin = 1; cfg_reg_sel_b = 1; settle_and_check("R3 pin=0 reg=1");
    sel_pin = 1; settle_and_check("R3 pin=1");
    cfg_use_pin = 0; cfg_reg_sel_b = 0; settle_and_check("R2 back to reg A");
    sel_pin = 0; settle_and_check("R2 pin ignored");
    // R8 override
    cfg_auto = 1; settle_and_check("R8 auto forces power");
    chk(pwr_a_en && pwr_b_en, "R8 both enables", {pwr_a_en, pwr_b_en}, 3);
    // R4 failover, R6 stay, R5 revert
    cfg_stay_b = 1;
    mon_a_ok = 0; settle_and_check("R4 failover to B");
    chk(sel_is_a === 1'b0, "R4 on B", sel_is_a, 0);
    mon_a_ok = 1; settle_and_check("R6 stays on B");
    chk(sel_is_a === 1'b0, "R6 still B", sel_is_a, 0);
    cfg_stay_b = 0; settle_and_check("R5 revert to A");
    chk(sel_is_a === 1'b1, "R5 back on A", sel_is_a, 1);
    // R7 holdover from A and from B
    mon_a_ok = 0; mon_b_ok = 0; settle_and_check("R7 both bad on A");
    chk(holdover_n === 1'b0 && sel_is_a === 1'b1, "R7 holdover keeps A", {holdover_n, sel_is_a}, 1);
    mon_b_ok = 1; settle_and_check("R4 to B from holdover");
    mon_b_ok = 0; settle_and_check("R7 both bad on B");
    chk(holdover_n === 1'b0 && sel_is_a === 1'b0, "R7 holdover keeps B", {holdover_n, sel_is_a}, 0);
    mon_a_ok = 1; mon_b_ok = 1; settle_and_check("R5 recover");
    // R9 differential blocks automatic operation
    cfg_diff = 1; settle_and_check("R9 diff manual A");
    mon_a_ok = 0; settle_and_check("R9 no failover");
    chk(sel_is_a === 1'b1 && holdover_n === 1'b1, "R9 stays A", {sel_is_a, holdover_n}, 3);
    mon_b_ok = 0; settle_and_check("R9 no holdover");
    mon_a_ok = 1; mon_b_ok = 1; cfg_diff = 0; cfg_auto = 0; settle_and_check("R2 idle");
    // R12 bypass
    mon_en = 1'b0;
    cfg_deglitch_off = 1; cfg_reg_sel_b = 1; settle_and_check("R12 bypass B");
    check_follow(1'b0, "R12 direct B");
    cfg_reg_sel_b = 0; settle_and_check("R12 bypass A");
    check_follow(1'b1, "R12 direct A");
    cfg_deglitch_off = 0; settle_and_check("R11 deglitch back on");
    repeat (SETTLE) @(negedge clk);
    mon_en = 1'b1;

    // Random: each step changes either the health group or the config group.
    for (int s = 0; s < RAND_STEPS; s++) begin
      if ($urandom_range(1, 0) == 0) begin
        mon_a_ok   = ($urandom_range(3, 0) != 0);
        mon_b_ok   = ($urandom_range(3, 0) != 0);
        mon_clk_ok = ($urandom_range(5, 0) != 0);
        mon_dld    = ($urandom_range(5, 0) != 0);
        sel_pin    = $urandom_range(1, 0);
      end else begin
        cfg_auto      = $urandom_range(1, 0);
        cfg_use_pin   = $urandom_range(1, 0);
        cfg_reg_sel_b = $urandom_range(1, 0);
        cfg_stay_b    = $urandom_range(1, 0);
        cfg_pwr_a     = $urandom_range(1, 0);
        cfg_pwr_b     = $urandom_range(1, 0);
        cfg_diff      = ($urandom_range(3, 0) == 0);
      end
      settle_and_check("R4 R5 R6 random");
    end
    check_follow(!exp_b, "R11 follows selected at end");
    chk(runts == 0, "R11 runt pulses", runts, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule